// File: doc/BRIEF.md
# Duplex Bus Self-Checking Comparator

This block sits inside one of two lockstep processor copies that share an address, data and check-bit bus. A role pin sets the copy to active or monitor. The active copy puts its own address, data and check bits on the bus. The monitor copy keeps its drivers off. For each bus write, the monitor compares the value it would have driven with the value the other copy actually drove.

Each compared bit becomes a rail pair: the expected bit, and the inverse of the bit seen on the bus. A tree of two-rail checker cells reduces all pairs to one pair. That result is a valid code word (01 or 10) when every bit agrees, and an invalid one (00 or 11) when any bit differs. Any single stuck-at fault inside the tree gives an invalid word for some equal input, so the tree can be tested with matching values alone. A single XNOR gate turns the final pair into a one-wire mismatch. That mismatch is sampled on write strobes in monitor role, and the result sets a per-cycle error flag and a sticky trip indication.

A three-state machine holds the role history. The states are ST_ACTIVE, ST_MONITOR and ST_TRIPPED. Reset enters ST_ACTIVE. Outside ST_TRIPPED, each clock moves to ST_MONITOR when the role pin is high and to ST_ACTIVE when it is low. A qualified mismatch moves either of those states to ST_TRIPPED. ST_TRIPPED is left only by reset.

Top module: `dbc_duplex_cmp`

## Requirements
- R1: With monitor_mode low, drv_oe is 1 and drv_addr, drv_data and drv_chk equal exp_addr, exp_data and exp_chk in the same cycle.
- R2: With monitor_mode high, drv_oe is 0 and drv_addr, drv_data and drv_chk are all zero.
- R3: When every observed bit (address, data and check) equals its expected bit, tree_rails is 2'b01 or 2'b10 in the same cycle.
- R4: When one or more observed bits differ from the expected bits, in any field, tree_rails is 2'b00 or 2'b11 in the same cycle.
- R5: err_flag is 1 during the cycle after a clock edge at which monitor_mode and wr_strobe were both high and a mismatch was present. Otherwise it is 0.
- R6: A mismatch sampled while wr_strobe is low, or while monitor_mode is low, leaves err_flag and err_sticky unchanged.
- R7: err_sticky rises at the same edge as the first err_flag. It stays at 1 through later role changes and clean cycles until reset.
- R8: While rst_n is low, and after it is released with no qualified mismatch yet, err_flag and err_sticky are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| monitor_mode | input | 1 | 1 selects the monitor role, 0 selects the active role |
| wr_strobe | input | 1 | Marks a bus write cycle |
| exp_addr | input | AW (32) | Address this copy would drive |
| exp_data | input | DW (32) | Data this copy would drive |
| exp_chk | input | CW (8) | Check bits this copy would drive |
| obs_addr | input | AW (32) | Address seen on the shared bus |
| obs_data | input | DW (32) | Data seen on the shared bus |
| obs_chk | input | CW (8) | Check bits seen on the shared bus |
| drv_oe | output | 1 | Bus driver enable |
| drv_addr | output | AW (32) | Address driven onto the bus |
| drv_data | output | DW (32) | Data driven onto the bus |
| drv_chk | output | CW (8) | Check bits driven onto the bus |
| tree_rails | output | 2 | Two-rail result of the checker tree |
| err_flag | output | 1 | Registered mismatch for the last qualified write |
| err_sticky | output | 1 | Trip indication held until reset |

## Verification
Matching traffic is run in both roles. It must keep tree_rails on valid code words and never raise an error, which separates a working tree from one that flags clean writes. Single-bit mismatches are placed at the edges of the address, data and check fields. They show that every leaf reaches the root and that the strobe-and-role qualification sets the error exactly one edge later. The same mismatches are also run with the strobe low or in the active role, which separates correct gating from an always-on compare. Multi-bit and all-bit mismatches, followed by role changes and clean cycles, show that an invalid word is not cancelled and that the trip holds.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_MONITOR = 2'd1,
        ST_TRIPPED = 2'd2
    } dbc_state_e;

    localparam logic [1:0] RAIL_PAD = 2'b01;
endpackage

// File: rtl/dbc_tr_cell.sv
module dbc_tr_cell (
    input  logic [1:0] x,
    input  logic [1:0] y,
    output logic [1:0] z
);
    // Two-rail checker: complementary inputs give a complementary output,
    // and any non-complementary input pair gives a non-complementary output.
    always_comb begin
        z[1] = (x[1] & y[1]) | (x[0] & y[0]);
        z[0] = (x[1] & y[0]) | (x[0] & y[1]);
    end
endmodule

// File: rtl/dbc_tr_tree.sv
module dbc_tr_tree #(
    parameter int N = 72
) (
    input  logic [N-1:0] exp_vec,
    input  logic [N-1:0] obs_vec,
    output logic [1:0]   rails
);
    import dbc_pkg::*;

    localparam int LVLS = (N > 1) ? $clog2(N) : 1;
    localparam int P    = 1 << LVLS;

    for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
        localparam int CNT = P >> l;
        logic [2*CNT-1:0] v;
        if (l == 0) begin : g_leaf
            for (genvar k = 0; k < P; k++) begin : g_pair
                if (k < N) begin : g_live
                    assign v[2*k+1:2*k] = {exp_vec[k], ~obs_vec[k]};
                end else begin : g_pad
                    assign v[2*k+1:2*k] = RAIL_PAD;
                end
            end
        end else begin : g_node
            for (genvar k = 0; k < CNT; k++) begin : g_cell
                dbc_tr_cell u_cell (
                    .x (g_lvl[l-1].v[4*k+1:4*k]),
                    .y (g_lvl[l-1].v[4*k+3:4*k+2]),
                    .z (v[2*k+1:2*k])
                );
            end
        end
    end

    assign rails = g_lvl[LVLS].v[1:0];
endmodule

// File: rtl/dbc_duplex_cmp.sv
module dbc_duplex_cmp #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          monitor_mode,
    input  logic          wr_strobe,
    input  logic [AW-1:0] exp_addr,
    input  logic [DW-1:0] exp_data,
    input  logic [CW-1:0] exp_chk,
    input  logic [AW-1:0] obs_addr,
    input  logic [DW-1:0] obs_data,
    input  logic [CW-1:0] obs_chk,
    output logic          drv_oe,
    output logic [AW-1:0] drv_addr,
    output logic [DW-1:0] drv_data,
    output logic [CW-1:0] drv_chk,
    output logic [1:0]    tree_rails,
    output logic          err_flag,
    output logic          err_sticky
);
    import dbc_pkg::*;

    localparam int NB = AW + DW + CW;

    dbc_state_e    state_q, state_d;
    logic [NB-1:0] exp_vec, obs_vec;
    logic          miss;
    logic          hit;

    assign exp_vec = {exp_chk, exp_data, exp_addr};
    assign obs_vec = {obs_chk, obs_data, obs_addr};

    dbc_tr_tree #(.N(NB)) u_tree (
        .exp_vec (exp_vec),
        .obs_vec (obs_vec),
        .rails   (tree_rails)
    );

    // Single-rail conversion: equal rails mean an invalid code word.
    assign miss = ~(tree_rails[1] ^ tree_rails[0]);
    assign hit  = monitor_mode & wr_strobe & miss;

    // Bus drivers
    always_comb begin
        drv_oe   = ~monitor_mode;
        drv_addr = monitor_mode ? '0 : exp_addr;
        drv_data = monitor_mode ? '0 : exp_data;
        drv_chk  = monitor_mode ? '0 : exp_chk;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE, ST_MONITOR: begin
                if (hit)               state_d = ST_TRIPPED;
                else if (monitor_mode) state_d = ST_MONITOR;
                else                   state_d = ST_ACTIVE;
            end
            ST_TRIPPED: state_d = ST_TRIPPED;
            default:    state_d = ST_ACTIVE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_ACTIVE;
            err_flag <= 1'b0;
        end else begin
            state_q  <= state_d;
            err_flag <= hit;
        end
    end

    // Outputs
    always_comb begin
        err_sticky = (state_q == ST_TRIPPED);
    end

    p_drive_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        monitor_mode |-> (!drv_oe && drv_data == '0 && drv_addr == '0));
    p_valid_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_vec == obs_vec) |-> (tree_rails[1] != tree_rails[0]));
    p_invalid_diff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_vec != obs_vec) |-> (tree_rails[1] == tree_rails[0]));
    p_err_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(monitor_mode && wr_strobe));
    p_err_trips_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> err_sticky);
    p_sticky_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);
endmodule

// File: tb/dbc_duplex_cmp_tb.sv
`timescale 1ns/1ps
module dbc_duplex_cmp_tb_top;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          monitor_mode = 1'b0;
    logic          wr_strobe = 1'b0;
    logic [AW-1:0] exp_addr = '0, obs_addr = '0;
    logic [DW-1:0] exp_data = '0, obs_data = '0;
    logic [CW-1:0] exp_chk = '0, obs_chk = '0;
    logic          drv_oe;
    logic [AW-1:0] drv_addr;
    logic [DW-1:0] drv_data;
    logic [CW-1:0] drv_chk;
    logic [1:0]    tree_rails;
    logic          err_flag, err_sticky;

    int n_chk = 0;
    int n_bad = 0;
    logic m_err = 1'b0;
    logic m_sticky = 1'b0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    dbc_duplex_cmp #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .monitor_mode(monitor_mode), .wr_strobe(wr_strobe),
        .exp_addr(exp_addr), .exp_data(exp_data), .exp_chk(exp_chk),
        .obs_addr(obs_addr), .obs_data(obs_data), .obs_chk(obs_chk),
        .drv_oe(drv_oe), .drv_addr(drv_addr), .drv_data(drv_data), .drv_chk(drv_chk),
        .tree_rails(tree_rails), .err_flag(err_flag), .err_sticky(err_sticky)
    );

    // Behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_err    <= 1'b0;
            m_sticky <= 1'b0;
        end else begin
            m_err    <= monitor_mode && wr_strobe &&
                        ({exp_chk, exp_data, exp_addr} != {obs_chk, obs_data, obs_addr});
            if (monitor_mode && wr_strobe &&
                ({exp_chk, exp_data, exp_addr} != {obs_chk, obs_data, obs_addr}))
                m_sticky <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic cyc(input bit mon, input bit strb,
                       input logic [AW-1:0] ea, input logic [DW-1:0] ed, input logic [CW-1:0] ec,
                       input logic [AW-1:0] oa, input logic [DW-1:0] od, input logic [CW-1:0] oc);
        bit diff;
        @(negedge clk);
        monitor_mode = mon; wr_strobe = strb;
        exp_addr = ea; exp_data = ed; exp_chk = ec;
        obs_addr = oa; obs_data = od; obs_chk = oc;
        diff = ({ec, ed, ea} != {oc, od, oa});
        #1;
        if (!mon)
            chk(drv_oe && drv_addr == ea && drv_data == ed && drv_chk == ec, "R1",
                {drv_oe, drv_chk, drv_data, drv_addr}, {1'b1, ec, ed, ea});
        else
            chk(!drv_oe && drv_addr == '0 && drv_data == '0 && drv_chk == '0, "R2",
                {drv_oe, drv_chk, drv_data, drv_addr}, 128'd0);
        if (!diff) chk(tree_rails == 2'b01 || tree_rails == 2'b10, "R3", tree_rails, 2'b01);
        else       chk(tree_rails == 2'b00 || tree_rails == 2'b11, "R4", tree_rails, 2'b00);
        @(posedge clk);
        #1;
        if (diff && !(mon && strb))
            chk(err_flag == m_err && err_sticky == m_sticky, "R6",
                {err_flag, err_sticky}, {m_err, m_sticky});
        else
            chk(err_flag == m_err, "R5", err_flag, m_err);
        chk(err_sticky == m_sticky, "R7", err_sticky, m_sticky);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(err_flag == 1'b0 && err_sticky == 1'b0, "R8", {err_flag, err_sticky}, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : stim
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [CW-1:0] c;
        do_reset();
        // Active role, random traffic including mismatches: never errors (R1, R6)
        for (int i = 0; i < 20; i++) begin
            a = $urandom; d = $urandom; c = 8'($urandom);
            cyc(1'b0, 1'b1, a, d, c, a ^ 32'($urandom), d, c);
        end
        // Monitor role, equal writes: valid rails, no error (R2, R3)
        for (int i = 0; i < 20; i++) begin
            a = $urandom; d = $urandom; c = 8'($urandom);
            cyc(1'b1, 1'b1, a, d, c, a, d, c);
        end
        cyc(1'b1, 1'b1, '0, '0, '0, '0, '0, '0);
        cyc(1'b1, 1'b1, '1, '1, '1, '1, '1, '1);
        // Monitor role, mismatch with strobe low: ignored (R6)
        for (int i = 0; i < 10; i++) begin
            a = $urandom; d = $urandom; c = 8'($urandom);
            cyc(1'b1, 1'b0, a, d, c, a, d ^ 32'h1, c);
        end
        // Single-bit mismatch in each field edge, reset between (R4, R5, R7)
        for (int f = 0; f < 6; f++) begin
            a = $urandom; d = $urandom; c = 8'($urandom);
            case (f)
                0: cyc(1'b1, 1'b1, a, d, c, a ^ 32'h1, d, c);
                1: cyc(1'b1, 1'b1, a, d, c, a ^ 32'h8000_0000, d, c);
                2: cyc(1'b1, 1'b1, a, d, c, a, d ^ 32'h1, c);
                3: cyc(1'b1, 1'b1, a, d, c, a, d ^ 32'h8000_0000, c);
                4: cyc(1'b1, 1'b1, a, d, c, a, d, c ^ 8'h01);
                default: cyc(1'b1, 1'b1, a, d, c, a, d, c ^ 8'h80);
            endcase
            // clean cycles and role switches keep the trip (R7)
            cyc(1'b1, 1'b1, a, d, c, a, d, c);
            cyc(1'b0, 1'b1, a, d, c, a, d, c);
            cyc(1'b1, 1'b0, a, d, c, a, d, c);
            do_reset();
        end
        // Multi-bit and all-bit mismatches (R4, R5)
        a = $urandom; d = $urandom; c = 8'($urandom);
        cyc(1'b1, 1'b1, a, d, c, a ^ 32'h3, d, c);
        cyc(1'b1, 1'b1, a, d, c, ~a, ~d, ~c);
        cyc(1'b1, 1'b1, a, d, c, a, d ^ 32'h0001_0100, c ^ 8'h11);
        cyc(1'b1, 1'b1, a, d, c, a, d, c);
        do_reset();
        for (int i = 0; i < 40; i++) begin
            a = $urandom; d = $urandom; c = 8'($urandom);
            cyc(1'($urandom), 1'($urandom), a, d, c,
                (($urandom % 4) == 0) ? a ^ (32'h1 << ($urandom % 32)) : a, d, c);
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule